// File: doc/BRIEF.md
# Packed-Vector Shift-Right-and-Insert Unit

This block carries out a right shift with insert on packed vector lanes. An immediate field selects the element width and the shift distance. Each lane of the source vector is shifted right logically by that distance. The result is then written over the matching lane of the current destination vector, but only in the bit positions the shift fills with data. The top bits that a plain shift would clear keep the destination's old contents. A caller uses it to assemble bit fields from two registers in one step. It supplies both operands and the 7-bit immediate, split into a 4-bit upper part and a 3-bit lower part, together with a width-select bit and a scalar-mode flag.

The unit decodes the immediate into an element width, a shift distance and a lane count. It merges every lane in parallel and registers the result. It also reports two kinds of encoding that it cannot execute: encodings that belong to another operation, and reserved or undefined ones. In both cases it returns zero instead of a result.

Top module: `sri_insert_unit`

## Requirements
- R1: For each lane, result = (destination lane AND NOT m) OR (source lane >> s), where m is an all-ones value of lane width shifted right logically by s, and >> is a logical shift.
- R2: The element width E is set by the most significant 1 in the upper immediate `in_imm_hi`: bit 3 gives 64, bit 2 gives 32, bit 1 gives 16 and bit 0 gives 8. Lower bits are ignored.
- R3: The shift distance is s = 2*E - {in_imm_hi, in_imm_lo}, read as an unsigned 7-bit value. For a legal encoding, s lies between 1 and E.
- R4: In vector mode (`in_scalar`=0), the operated width is 64 bits when `in_q`=0 and 128 bits when `in_q`=1. The number of lanes is that width divided by E.
- R5: In vector mode with `in_imm_hi`=0000, `out_unhandled` is 1, `out_undef` is 0 and `out_result` is zero.
- R6: In vector mode with `in_imm_hi[3]`=1 and `in_q`=0, `out_undef` is 1 and `out_result` is zero.
- R7: In scalar mode (`in_scalar`=1), the operation acts on one 64-bit lane with s = 128 - immediate, and `in_q` has no effect. If `in_imm_hi[3]`=0, `out_undef` is 1 and `out_result` is zero.
- R8: Bits shifted out of the low end of a lane are dropped. They never appear in the lane below.
- R9: When s equals E, each lane of the result equals the old destination lane.
- R10: When the operated width is 64 bits (vector with `in_q`=0, or scalar mode), `out_result[127:64]` is zero.
- R11: `out_result`, `out_undef` and `out_unhandled` update on the clock edge that samples `in_valid`=1. `out_valid` is high in exactly the cycle after each accepted input. Without a valid input, the outputs hold.
- R12: A synchronous active-low reset clears `out_valid`, `out_result`, `out_undef` and `out_unhandled`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and immediate are valid this cycle |
| in_src | input | 128 | Source vector to be shifted |
| in_dst | input | 128 | Current destination vector that supplies the kept bits |
| in_imm_hi | input | 4 | Upper immediate part; its top set bit selects the element width |
| in_imm_lo | input | 3 | Lower immediate part |
| in_q | input | 1 | Vector width select: 0 gives 64 bits, 1 gives 128 bits |
| in_scalar | input | 1 | 1 selects the single 64-bit lane form |
| out_valid | output | 1 | Result registers were loaded on the previous edge |
| out_result | output | 128 | Merged result vector |
| out_undef | output | 1 | Encoding is reserved or undefined |
| out_unhandled | output | 1 | Encoding belongs to a different operation |

## Verification
Every element width is tried at both vector widths and in scalar mode, with shift distances of 1, half the width and the full width. Every result is compared with a model that computes each bit on its own. A shift of 1 exposes errors in the mask edge. The half-width shift exposes wrong mask or shift alignment. The full-width shift shows whether the whole destination lane survives without a zero-width artifact. An all-ones source with a zero destination tells a lane-local shift apart from a whole-vector shift that leaks bits into the next lane down. Separate cases exercise the no-size, reserved and scalar-undefined encodings, a change of `in_q` in scalar mode, output timing and hold, and a reset in mid-run.

// File: rtl/sri_pkg.sv
// Package: shared sizes and the decoded-immediate record for the
// shift-right-and-insert unit.
// Assumes: element widths are BASE_W << k for k in 0..NUM_SIZES-1.
package sri_pkg;
    localparam int DATA_W    = 128;
    localparam int HALF_W    = DATA_W / 2;
    localparam int BASE_W    = 8;
    localparam int NUM_SIZES = 4;
    localparam int HI_W      = 4;
    localparam int LO_W      = 3;
    localparam int IMM_W     = HI_W + LO_W;
    localparam int IDX_W     = $clog2(NUM_SIZES);
    localparam int MAX_EW    = BASE_W << (NUM_SIZES - 1);
    localparam int SHM1_W    = $clog2(MAX_EW);
    localparam int CNT_W     = $clog2(DATA_W / BASE_W) + 1;

    typedef struct packed {
        logic [IDX_W-1:0]     size_idx;   // index of selected element width
        logic [NUM_SIZES-1:0] size_oh;    // one-hot form of size_idx
        logic [7:0]           esize;      // element width in bits
        logic [7:0]           shift;      // right shift distance
        logic [CNT_W-1:0]     lanes;      // number of active lanes
        logic                 wide;       // operated width is DATA_W
        logic                 undef;      // reserved or undefined encoding
        logic                 unhandled;  // encoding of another operation
    } sri_dec_t;
endpackage

// File: rtl/sri_imm_decode.sv
// Module: sri_imm_decode
// Turns the split immediate, width bit and scalar flag into element
// width, shift distance, lane count and the two reject flags.
// Assumes: purely combinational; outputs are meaningful only when
// neither reject flag is set.
module sri_imm_decode
    import sri_pkg::*;
(
    input  logic [HI_W-1:0] imm_hi,
    input  logic [LO_W-1:0] imm_lo,
    input  logic            q,
    input  logic            scalar,
    output sri_dec_t        dec
);
    logic [IMM_W-1:0] imm;
    logic [IDX_W-1:0] idx;

    assign imm = {imm_hi, imm_lo};

    // Pick the element-width index from the most significant set bit.
    always_comb begin
        idx = '0;
        for (int b = 0; b < HI_W; b++) begin
            if (imm_hi[b]) idx = IDX_W'(b);
        end
        if (scalar) idx = IDX_W'(NUM_SIZES - 1);
    end

    // Derive width, shift, lane count and the encoding checks.
    always_comb begin
        dec          = '0;
        dec.size_idx = idx;
        dec.size_oh  = NUM_SIZES'(1) << idx;
        dec.esize    = 8'(BASE_W) << idx;
        dec.shift    = 8'((dec.esize << 1) - {1'b0, imm});
        dec.wide     = !scalar && q;
        dec.lanes    = (dec.wide ? CNT_W'(DATA_W / BASE_W)
                                 : CNT_W'(HALF_W / BASE_W)) >> idx;
        if (scalar) begin
            dec.lanes     = CNT_W'(1);
            dec.undef     = !imm_hi[HI_W-1];
            dec.unhandled = 1'b0;
        end else begin
            dec.unhandled = (imm_hi == '0);
            dec.undef     = imm_hi[HI_W-1] && !q;
        end
    end
endmodule

// File: rtl/sri_lane.sv
// Module: sri_lane
// One lane of width W: logical right shift of the source and insertion
// into the destination below the vacated top bits.
// Assumes: shm1 is the shift distance minus one (distance 1..W), so the
// two-step shift never uses a distance of W or more.
module sri_lane #(
    parameter int W  = 8,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  src,
    input  logic [W-1:0]  dst,
    input  logic [SW-1:0] shm1,
    output logic [W-1:0]  res
);
    logic [W-1:0] keep_mask;
    logic [W-1:0] shifted;

    // Shift in two legal steps so that a full-width distance yields zero.
    always_comb begin
        keep_mask = ({W{1'b1}} >> shm1) >> 1;
        shifted   = (src >> shm1) >> 1;
        res       = (dst & ~keep_mask) | shifted;
    end
endmodule

// File: rtl/sri_size_group.sv
// Module: sri_size_group
// Splits the full data word into lanes of width W and runs one
// sri_lane per lane, so no bit can cross a lane boundary.
// Assumes: DW is a multiple of W.
module sri_size_group #(
    parameter int DW = 128,
    parameter int W  = 8,
    localparam int SW    = $clog2(W),
    localparam int LANES = DW / W
) (
    input  logic [DW-1:0] src,
    input  logic [DW-1:0] dst,
    input  logic [SW-1:0] shm1,
    output logic [DW-1:0] res
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        sri_lane #(.W(W)) u_lane (
            .src  (src[l*W +: W]),
            .dst  (dst[l*W +: W]),
            .shm1 (shm1),
            .res  (res[l*W +: W])
        );
    end
endmodule

// File: rtl/sri_insert_unit.sv
// Module: sri_insert_unit (top)
// Decodes the immediate, computes the merged vector for every element
// width in parallel, selects one, trims it to the operated width and
// registers it with the reject flags.
// Assumes: synchronous active-low reset; one input per cycle at most.
module sri_insert_unit
    import sri_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_src,
    input  logic [DATA_W-1:0] in_dst,
    input  logic [HI_W-1:0]   in_imm_hi,
    input  logic [LO_W-1:0]   in_imm_lo,
    input  logic              in_q,
    input  logic              in_scalar,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_undef,
    output logic              out_unhandled
);
    sri_dec_t          dec;
    logic [SHM1_W-1:0] shm1;
    logic [DATA_W-1:0] group_res [NUM_SIZES];
    logic [DATA_W-1:0] merged;
    logic              dec_ok;

    sri_imm_decode u_dec (
        .imm_hi (in_imm_hi),
        .imm_lo (in_imm_lo),
        .q      (in_q),
        .scalar (in_scalar),
        .dec    (dec)
    );

    assign shm1   = SHM1_W'(dec.shift - 8'd1);
    assign dec_ok = !dec.undef && !dec.unhandled;

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
        localparam int GW  = BASE_W << k;
        localparam int GSW = $clog2(GW);
        sri_size_group #(.DW(DATA_W), .W(GW)) u_grp (
            .src  (in_src),
            .dst  (in_dst),
            .shm1 (shm1[GSW-1:0]),
            .res  (group_res[k])
        );
    end

    // Choose the selected width, clear the unused half and rejected results.
    always_comb begin
        merged = group_res[dec.size_idx];
        if (!dec.wide) merged[DATA_W-1:HALF_W] = '0;
        if (!dec_ok)   merged = '0;
    end

    // Register result and flags on valid input; valid strobe follows input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_result    <= '0;
            out_undef     <= 1'b0;
            out_unhandled <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result    <= merged;
                out_undef     <= dec.undef;
                out_unhandled <= dec.unhandled;
            end
        end
    end

    // R11: output valid tracks the input strobe one cycle later.
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r11_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R11: outputs hold when nothing is accepted.
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result));
    // R12: reset clears all registered outputs.
    a_r12_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_result == '0 && !out_undef && !out_unhandled));
    // R2: exactly one width is chosen.
    a_r2_one_size: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> $onehot(dec.size_oh));
    // R3: legal encodings give a shift between 1 and the element width.
    a_r3_shift_range: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_ok) |-> (dec.shift >= 8'd1 && dec.shift <= dec.esize));
    // R4: lanes times width fills the operated width.
    a_r4_lane_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_ok) |->
        (int'(dec.lanes) * int'(dec.esize) == (dec.wide ? DATA_W : HALF_W)));
    // R5: a zero upper immediate in vector mode is reported as unhandled.
    a_r5_unhandled: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_scalar && in_imm_hi == '0) |=>
        (out_unhandled && !out_undef && out_result == '0));
    // R6: 64-bit elements on a 64-bit vector are reserved.
    a_r6_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_scalar && in_imm_hi[HI_W-1] && !in_q) |=>
        (out_undef && out_result == '0));
    // R7: scalar form needs the top immediate bit.
    a_r7_scalar_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_scalar && !in_imm_hi[HI_W-1]) |=> out_undef);
    // R9: a full-width shift returns the old destination in the low half.
    a_r9_full_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_ok && dec.shift == dec.esize) |=>
        (out_result[HALF_W-1:0] == $past(in_dst[HALF_W-1:0])));
    // R10: narrow operations leave the upper half at zero.
    a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_scalar || !in_q)) |=> (out_result[DATA_W-1:HALF_W] == '0));
endmodule

// File: tb/tb_sri_insert_unit.sv
module tb_sri_insert_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] in_src = '0;
    logic [127:0] in_dst = '0;
    logic [3:0]   in_imm_hi = '0;
    logic [2:0]   in_imm_lo = '0;
    logic         in_q = 1'b0;
    logic         in_scalar = 1'b0;
    logic         out_valid;
    logic [127:0] out_result;
    logic         out_undef;
    logic         out_unhandled;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    sri_insert_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_src(in_src), .in_dst(in_dst),
        .in_imm_hi(in_imm_hi), .in_imm_lo(in_imm_lo),
        .in_q(in_q), .in_scalar(in_scalar),
        .out_valid(out_valid), .out_result(out_result),
        .out_undef(out_undef), .out_unhandled(out_unhandled)
    );

    // Bit-by-bit reference built from the requirements.
    function automatic void ref_model(input logic [127:0] s, input logic [127:0] d,
                                      input logic [3:0] hi, input logic [2:0] lo,
                                      input logic q, input logic sc,
                                      output logic [127:0] r, output logic u,
                                      output logic nh);
        int e = 8;
        int width;
        int sh;
        r = '0; u = 1'b0; nh = 1'b0;
        for (int b = 0; b < 4; b++) if (hi[b]) e = 8 << b;
        if (sc) begin
            e = 64; width = 64; u = !hi[3];
        end else begin
            width = q ? 128 : 64;
            nh = (hi == 4'b0);
            u  = hi[3] && !q;
        end
        if (u || nh) return;
        sh = 2 * e - int'({hi, lo});
        for (int i = 0; i < width; i++) begin
            int p = i % e;
            int base = i - p;
            if (p < e - sh) r[i] = (p + sh < e) ? s[base + p + sh] : 1'b0;
            else            r[i] = d[i];
        end
    endfunction

    task automatic check_vec(input string req, input string what,
                             input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input string what,
                             input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Apply one operation and compare all outputs with the model.
    task automatic run_op(input string req, input logic [127:0] s, input logic [127:0] d,
                          input logic [6:0] imm, input logic q, input logic sc);
        logic [127:0] er;
        logic eu, en;
        ref_model(s, d, imm[6:3], imm[2:0], q, sc, er, eu, en);
        @(negedge clk);
        in_valid = 1'b1; in_src = s; in_dst = d;
        in_imm_hi = imm[6:3]; in_imm_lo = imm[2:0]; in_q = q; in_scalar = sc;
        @(negedge clk);
        in_valid = 1'b0;
        check_bit(req, "valid", out_valid, 1'b1);
        check_vec(req, "result", out_result, er);
        check_bit(req, "undef", out_undef, eu);
        check_bit(req, "unhandled", out_unhandled, en);
    endtask

    function automatic logic [127:0] pat(input int seed);
        return {32'h9E3779B9 * (seed + 1), 32'hC2B2AE35 ^ (seed * 7919),
                32'h85EBCA6B + seed * 31, 32'h27D4EB2F ^ (seed << 5)};
    endfunction

    task automatic t_reset_state;  // R12
        check_bit("R12", "valid after reset", out_valid, 1'b0);
        check_vec("R12", "result after reset", out_result, '0);
        check_bit("R12", "undef after reset", out_undef, 1'b0);
        check_bit("R12", "unhandled after reset", out_unhandled, 1'b0);
    endtask

    task automatic t_vector_sizes;  // R1 R2 R3 R4 R10
        int seed = 0;
        for (int k = 0; k < 4; k++) begin
            for (int q = 0; q < 2; q++) begin
                int e = 8 << k;
                int shs [3] = '{1, e / 2, e};
                if (k == 3 && q == 0) continue;
                foreach (shs[j]) begin
                    run_op("R1", pat(seed), pat(seed + 100), 7'(2 * e - shs[j]), q[0], 1'b0);
                    seed++;
                end
            end
        end
        // R2: lower upper-immediate bits do not change the width (32-bit, shift 3).
        run_op("R2", pat(50), pat(51), 7'(64 - 3), 1'b1, 1'b0);
    endtask

    task automatic t_scalar;  // R7
        int shs [3] = '{1, 32, 64};
        foreach (shs[j]) begin
            run_op("R7", pat(60 + j), pat(70 + j), 7'(128 - shs[j]), 1'b0, 1'b1);
            run_op("R7", pat(60 + j), pat(70 + j), 7'(128 - shs[j]), 1'b1, 1'b1);
        end
        run_op("R7", pat(80), pat(81), 7'b0111010, 1'b1, 1'b1);
        check_bit("R7", "scalar hi[3]=0 flagged", out_undef, 1'b1);
    endtask

    task automatic t_no_spill;  // R8
        run_op("R8", {128{1'b1}}, '0, 7'd15, 1'b1, 1'b0);
        check_vec("R8", "bytes shifted by one", out_result, {16{8'h7F}});
        run_op("R8", {128{1'b1}}, '0, 7'(32 - 4), 1'b1, 1'b0);
        check_vec("R8", "halves shifted by four", out_result, {8{16'h0FFF}});
    endtask

    task automatic t_full_shift;  // R9
        for (int k = 0; k < 4; k++) begin
            int e = 8 << k;
            run_op("R9", pat(90 + k), pat(95 + k), 7'(e), 1'b1, 1'b0);
            check_vec("R9", "destination kept", out_result, pat(95 + k));
        end
    endtask

    task automatic t_unhandled;  // R5
        run_op("R5", pat(3), pat(4), 7'b0000101, 1'b1, 1'b0);
        check_vec("R5", "zero result", out_result, '0);
    endtask

    task automatic t_reserved;  // R6
        run_op("R6", pat(5), pat(6), 7'd100, 1'b0, 1'b0);
        check_bit("R6", "reserved flagged", out_undef, 1'b1);
    endtask

    task automatic t_timing;  // R11
        logic [127:0] held;
        run_op("R11", pat(7), pat(8), 7'd12, 1'b1, 1'b0);
        held = out_result;
        in_src = pat(9); in_imm_hi = 4'b0; in_q = 1'b0;
        @(negedge clk);
        check_bit("R11", "valid drops", out_valid, 1'b0);
        check_vec("R11", "result holds", out_result, held);
        check_bit("R11", "unhandled holds", out_unhandled, 1'b0);
    endtask

    task automatic t_reset_mid;  // R12
        run_op("R12", pat(11), pat(12), 7'd40, 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1; in_imm_hi = 4'b0;
        @(negedge clk);
        rst_n = 1'b1; in_valid = 1'b0;
        t_reset_state();
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_vector_sizes();
        t_scalar();
        t_no_spill();
        t_full_shift();
        t_unhandled();
        t_reserved();
        t_timing();
        t_reset_mid();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule